// File: doc/BRIEF.md
# Program-Order Guard for Peripheral Bus Accesses

This block sits between the memory port of a pipelined processor and a peripheral bus that takes one access at a time. The processor may present a read before an older write to another address. The block holds that write in a one-entry buffer. Each access carries a program-order tag, so the block can tell whether the read is newer than the write. Most of the time the read goes to the bus first, which saves the write latency.

The address space is split into equal regions by its top address bits. A protection map has one enable bit per region. When the buffered (or arriving) write or the newer read falls in a protected region, the read is held back. The write then goes out first and the read follows. A newer read to the same address as the write is always held back, whatever the map says.

Every cycle a read spends waiting for ordering is counted on a free-running stall counter. The map resets to a default set of regions and can be rewritten through a one-cycle configuration strobe.

Top module: `bus_order_guard`

## Requirements
- R1: After reset, the bus is idle, `wr_rdy` is 1, `stall_cnt` is 0, and `prot_map` equals the default 8'h0E. Region number is `addr[15:13]` and bit n enables region n, so regions 1, 2 and 3 are protected.
- R2: A read that is newer than the buffered or arriving write is issued on the bus in the same cycle when three conditions hold: neither address is in a protected region, the addresses differ, and the write waits. `rd_rdy` follows `bus_rdy`.
- R3: When a newer read or the write targets a protected region, the write appears on the bus (`bus_we`=1) before the read. The read is not acknowledged until the write has completed.
- R4: A newer read to the same address as the write is ordered after the write even when no region is protected.
- R5: Tags are compared modulo 16. A read is newer when (`rd_tag` - `wr_tag`) mod 16 is between 1 and 7. A read that is not newer goes to the bus ahead of the write, even in a protected region.
- R6: At most one write is buffered. `wr_rdy` is 0 while it is buffered. A write offered in that time is not taken. The buffered write stays on the bus unchanged until `bus_rdy` is 1.
- R7: `stall_cnt` rises by exactly one for each cycle in which a valid read is held back for ordering.
- R8: A cycle with `cfg_we`=1 loads `cfg_data` into the map, which shows on `prot_map` and governs ordering from the next cycle on.
- R9: A read with no write present goes to the bus at once. `rd_rdy` equals `bus_rdy` and `rd_rdata` equals `bus_rdata` in that cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cfg_we | input | 1 | Load strobe for the protection map |
| cfg_data | input | 8 | New protection map, one bit per region |
| prot_map | output | 8 | Current protection map |
| wr_vld | input | 1 | Processor write request |
| wr_addr | input | 16 | Write address |
| wr_data | input | 16 | Write data |
| wr_tag | input | 4 | Program-order tag of the write |
| wr_rdy | output | 1 | Write taken into the buffer |
| rd_vld | input | 1 | Processor read request |
| rd_addr | input | 16 | Read address |
| rd_tag | input | 4 | Program-order tag of the read |
| rd_rdy | output | 1 | Read completes this cycle |
| rd_rdata | output | 16 | Read data |
| bus_vld | output | 1 | Bus access valid |
| bus_we | output | 1 | Bus access is a write |
| bus_addr | output | 16 | Bus address |
| bus_wdata | output | 16 | Bus write data |
| bus_rdy | input | 1 | Bus completes the access this cycle |
| bus_rdata | input | 16 | Bus read data |
| stall_cnt | output | 16 | Count of cycles a read waited for ordering |

## Verification
The bench builds the block with its defaults: 16-bit address and data, 4-bit tags and eight regions chosen by the top three address bits. The small tag width lets a handful of accesses wrap the tag and test the modulo age compare in both directions. Eight regions let the bench place either side of a pair inside or outside a protected region just by choosing the top address nibble. It also rewrites the map so that the same address pair changes between bypass and strict order.

// File: rtl/obu_pkg.sv
package obu_pkg;
  // which access owns the peripheral bus in the current cycle
  typedef enum logic [1:0] {
    ISS_NONE  = 2'd0,
    ISS_READ  = 2'd1,
    ISS_WRITE = 2'd2
  } obu_issue_e;
endpackage

// File: rtl/obu_region_map.sv
module obu_region_map #(
  parameter int unsigned RGN_W = 3,
  localparam int unsigned NREG = 1 << RGN_W
) (
  input  logic [RGN_W-1:0] rgn,
  input  logic [NREG-1:0]  prot,
  output logic             hit
);
  logic [NREG-1:0] sel;

  for (genvar g = 0; g < NREG; g++) begin : g_rgn
    assign sel[g] = (rgn == RGN_W'(g)) && prot[g];
  end

  assign hit = |sel;
endmodule

// File: rtl/obu_wbuf.sv
module obu_wbuf #(
  parameter int unsigned AW    = 16,
  parameter int unsigned DW    = 16,
  parameter int unsigned TAG_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ld,
  input  logic             done,
  input  logic [AW-1:0]    in_addr,
  input  logic [DW-1:0]    in_data,
  input  logic [TAG_W-1:0] in_tag,
  output logic             pend,
  output logic [AW-1:0]    addr,
  output logic [DW-1:0]    data,
  output logic [TAG_W-1:0] tag
);
  logic pend_d;

  always_comb begin
    pend_d = pend;
    if (done)    pend_d = 1'b0;
    else if (ld) pend_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend <= 1'b0;
    else        pend <= pend_d;
  end

  // payload registers: clock enable only, contents are don't-care when empty
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr <= '0;
      data <= '0;
      tag  <= '0;
    end else if (ld) begin
      addr <= in_addr;
      data <= in_data;
      tag  <= in_tag;
    end
  end

  AST_WR_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
    (ld && !pend) |=> pend) else $error("write not captured"); // R6
  AST_WR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (pend && !done) |=> (pend && $stable(addr) && $stable(data))) else $error("buffered write changed"); // R6
endmodule

// File: rtl/obu_arb.sv
module obu_arb
  import obu_pkg::*;
#(
  parameter int unsigned AW    = 16,
  parameter int unsigned DW    = 16,
  parameter int unsigned TAG_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmp_vld,
  input  logic [AW-1:0]    cmp_addr,
  input  logic [TAG_W-1:0] cmp_tag,
  input  logic             cmp_prot,
  input  logic             pend,
  input  logic [AW-1:0]    pend_addr,
  input  logic [DW-1:0]    pend_data,
  input  logic             rd_vld,
  input  logic [AW-1:0]    rd_addr,
  input  logic [TAG_W-1:0] rd_tag,
  input  logic             rd_prot,
  input  logic             bus_rdy,
  output logic             bus_vld,
  output logic             bus_we,
  output logic [AW-1:0]    bus_addr,
  output logic [DW-1:0]    bus_wdata,
  output logic             rd_rdy,
  output logic             wr_done,
  output logic             hold
);
  logic [TAG_W-1:0] age;
  logic             rd_newer;
  logic             ord_need;
  obu_issue_e       iss;

  // modulo age: read is younger when the difference lies in the lower half
  assign age      = rd_tag - cmp_tag;
  assign rd_newer = (age != '0) && !age[TAG_W-1];
  assign ord_need = cmp_vld && rd_newer && (cmp_prot || rd_prot || (cmp_addr == rd_addr));
  assign hold     = rd_vld && ord_need;

  always_comb begin
    if (rd_vld && !ord_need) iss = ISS_READ;
    else if (pend)           iss = ISS_WRITE;
    else                     iss = ISS_NONE;
  end

  assign bus_vld   = (iss != ISS_NONE);
  assign bus_we    = (iss == ISS_WRITE);
  assign bus_addr  = (iss == ISS_READ) ? rd_addr : pend_addr;
  assign bus_wdata = pend_data;
  assign rd_rdy    = (iss == ISS_READ) && bus_rdy;
  assign wr_done   = (iss == ISS_WRITE) && bus_rdy;

  AST_ORDER_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_rdy && pend && (cmp_prot || rd_prot)) |-> !rd_newer) else $error("protected read overtook write"); // R3
  AST_BUS_READ_SRC: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_vld && !bus_we) |-> rd_vld) else $error("read issued with no request"); // R9
endmodule

// File: rtl/bus_order_guard.sv
module bus_order_guard #(
  parameter int unsigned AW       = 16,
  parameter int unsigned DW       = 16,
  parameter int unsigned TAG_W    = 4,
  parameter int unsigned RGN_W    = 3,
  parameter int unsigned CNT_W    = 16,
  parameter int unsigned PROT_RST = 32'h0000_000E,
  localparam int unsigned NREG    = 1 << RGN_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_we,
  input  logic [NREG-1:0]  cfg_data,
  output logic [NREG-1:0]  prot_map,
  input  logic             wr_vld,
  input  logic [AW-1:0]    wr_addr,
  input  logic [DW-1:0]    wr_data,
  input  logic [TAG_W-1:0] wr_tag,
  output logic             wr_rdy,
  input  logic             rd_vld,
  input  logic [AW-1:0]    rd_addr,
  input  logic [TAG_W-1:0] rd_tag,
  output logic             rd_rdy,
  output logic [DW-1:0]    rd_rdata,
  output logic             bus_vld,
  output logic             bus_we,
  output logic [AW-1:0]    bus_addr,
  output logic [DW-1:0]    bus_wdata,
  input  logic             bus_rdy,
  input  logic [DW-1:0]    bus_rdata,
  output logic [CNT_W-1:0] stall_cnt
);
  localparam logic [NREG-1:0] MAP_RST = NREG'(PROT_RST);

  logic             rs0, rst_sq;
  logic [NREG-1:0]  map_d;
  logic [CNT_W-1:0] cnt_d;
  logic             pend, wr_ld, wr_done, hold;
  logic [AW-1:0]    pend_addr, cmp_addr;
  logic [DW-1:0]    pend_data;
  logic [TAG_W-1:0] pend_tag, cmp_tag;
  logic             cmp_vld, cmp_prot, rd_prot;

  // reset: asserted at once, released after two clock edges
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) {rst_sq, rs0} <= 2'b00;
    else        {rst_sq, rs0} <= {rs0, 1'b1};
  end

  assign map_d = cfg_we ? cfg_data : prot_map;
  always_ff @(posedge clk or negedge rst_sq) begin
    if (!rst_sq) prot_map <= MAP_RST;
    else         prot_map <= map_d;
  end

  assign cnt_d = hold ? stall_cnt + CNT_W'(1) : stall_cnt;
  always_ff @(posedge clk or negedge rst_sq) begin
    if (!rst_sq) stall_cnt <= '0;
    else         stall_cnt <= cnt_d;
  end

  assign wr_rdy = !pend;
  assign wr_ld  = wr_vld && wr_rdy;

  obu_wbuf #(.AW(AW), .DW(DW), .TAG_W(TAG_W)) u_wbuf (
    .clk(clk), .rst_n(rst_sq), .ld(wr_ld), .done(wr_done),
    .in_addr(wr_addr), .in_data(wr_data), .in_tag(wr_tag),
    .pend(pend), .addr(pend_addr), .data(pend_data), .tag(pend_tag)
  );

  // the write a read is compared with: buffered one, else the one arriving now
  assign cmp_vld  = pend || wr_vld;
  assign cmp_addr = pend ? pend_addr : wr_addr;
  assign cmp_tag  = pend ? pend_tag  : wr_tag;

  obu_region_map #(.RGN_W(RGN_W)) u_map_wr (
    .rgn(cmp_addr[AW-1 -: RGN_W]), .prot(prot_map), .hit(cmp_prot)
  );
  obu_region_map #(.RGN_W(RGN_W)) u_map_rd (
    .rgn(rd_addr[AW-1 -: RGN_W]), .prot(prot_map), .hit(rd_prot)
  );

  obu_arb #(.AW(AW), .DW(DW), .TAG_W(TAG_W)) u_arb (
    .clk(clk), .rst_n(rst_sq),
    .cmp_vld(cmp_vld), .cmp_addr(cmp_addr), .cmp_tag(cmp_tag), .cmp_prot(cmp_prot),
    .pend(pend), .pend_addr(pend_addr), .pend_data(pend_data),
    .rd_vld(rd_vld), .rd_addr(rd_addr), .rd_tag(rd_tag), .rd_prot(rd_prot),
    .bus_rdy(bus_rdy), .bus_vld(bus_vld), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .rd_rdy(rd_rdy), .wr_done(wr_done), .hold(hold)
  );

  assign rd_rdata = bus_rdata;

  AST_STALL_STEP: assert property (@(posedge clk) disable iff (!rst_sq)
    1'b1 |=> ((stall_cnt == $past(stall_cnt)) || (stall_cnt == $past(stall_cnt) + CNT_W'(1))))
    else $error("stall count jumped"); // R7
  AST_STALL_ON_WAIT: assert property (@(posedge clk) disable iff (!rst_sq)
    (rd_vld && !rd_rdy && !bus_vld) |=> (stall_cnt != $past(stall_cnt))) else $error("idle wait not counted"); // R7
  AST_CFG_TAKE: assert property (@(posedge clk) disable iff (!rst_sq)
    cfg_we |=> (prot_map == $past(cfg_data))) else $error("map not loaded"); // R8
endmodule

// File: tb/bus_order_guard_bench.sv
module bus_order_guard_bench;
  localparam int CLK_P = 10;

  typedef struct packed {
    logic [15:0] wa;
    logic [15:0] ra;
    logic [3:0]  wt;
    logic [3:0]  rt;
    logic        ord;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 7;
  localparam vec_t VEC [NV] = '{
    '{16'h8010, 16'h8020, 4'd1,  4'd2, 1'b0, 4'd2},  // R2 both unprotected
    '{16'h2004, 16'h8020, 4'd3,  4'd4, 1'b1, 4'd3},  // R3 write protected
    '{16'h8004, 16'h4008, 4'd5,  4'd6, 1'b1, 4'd3},  // R3 read protected
    '{16'h0100, 16'h0100, 4'd7,  4'd8, 1'b1, 4'd4},  // R4 same address
    '{16'h2004, 16'h6000, 4'd9,  4'd8, 1'b0, 4'd5},  // R5 read older
    '{16'hA000, 16'hE000, 4'd15, 4'd0, 1'b0, 4'd2},  // R2 tag wrap, unprotected
    '{16'h6000, 16'h8000, 4'd15, 4'd1, 1'b1, 4'd5}   // R5 wrapped tag is newer
  };

  logic        clk = 1'b0;
  logic        rst_n;
  logic        cfg_we;
  logic [7:0]  cfg_data, prot_map;
  logic        wr_vld, wr_rdy, rd_vld, rd_rdy;
  logic [15:0] wr_addr, wr_data, rd_addr, rd_rdata;
  logic [3:0]  wr_tag, rd_tag;
  logic        bus_vld, bus_we, bus_rdy;
  logic [15:0] bus_addr, bus_wdata, bus_rdata, stall_cnt;

  int n_chk = 0;
  int n_err = 0;
  bit done  = 1'b0;

  always #(CLK_P/2) clk = ~clk;

  bus_order_guard u_bus_order_guard (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_data(cfg_data), .prot_map(prot_map),
    .wr_vld(wr_vld), .wr_addr(wr_addr), .wr_data(wr_data), .wr_tag(wr_tag), .wr_rdy(wr_rdy),
    .rd_vld(rd_vld), .rd_addr(rd_addr), .rd_tag(rd_tag), .rd_rdy(rd_rdy), .rd_rdata(rd_rdata),
    .bus_vld(bus_vld), .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdy(bus_rdy), .bus_rdata(bus_rdata), .stall_cnt(stall_cnt)
  );

  task automatic check(string what, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual %h expected %h", what, act, exp);
    end
  endtask

  // one write and one read offered together; ord says the write must lead
  task automatic run_pair(logic [15:0] wa, logic [15:0] ra, logic [3:0] wt,
                          logic [3:0] rt, logic ord, string req);
    logic [15:0] base;
    @(negedge clk);
    wr_vld = 1'b1; wr_addr = wa; wr_data = wa ^ 16'hFFFF; wr_tag = wt;
    rd_vld = 1'b1; rd_addr = ra; rd_tag = rt; bus_rdy = 1'b1;
    base = stall_cnt;
    #1;
    if (ord) begin
      check({req, " read held first cycle"}, {bus_vld, rd_rdy}, 2'b00);
    end else begin
      check({req, " read leads"}, {bus_vld, bus_we, rd_rdy}, 3'b101);
      check({req, " read address"}, bus_addr, ra);
    end
    @(negedge clk);
    wr_vld = 1'b0;
    if (!ord) rd_vld = 1'b0;
    #1;
    check({req, " write on bus"}, {bus_vld, bus_we, rd_rdy}, 3'b110);
    check({req, " write address"}, bus_addr, wa);
    check({req, " write data"}, bus_wdata, wa ^ 16'hFFFF);
    if (ord) begin
      @(negedge clk); #1;
      check({req, " read after write"}, {bus_vld, bus_we, rd_rdy}, 3'b101);
      check({req, " read address"}, bus_addr, ra);
    end
    @(negedge clk);
    rd_vld = 1'b0;
    #1;
    check({req, " bus idle"}, bus_vld, 1'b0);
    check({req, " R7 stall delta"}, stall_cnt - base, ord ? 16'd2 : 16'd0);
  endtask

  initial begin
    #(CLK_P * 100000);
    if (!done) begin
      n_err++;
      n_chk++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; cfg_we = 1'b0; cfg_data = '0;
    wr_vld = 1'b0; wr_addr = '0; wr_data = '0; wr_tag = '0;
    rd_vld = 1'b0; rd_addr = '0; rd_tag = '0;
    bus_rdy = 1'b1; bus_rdata = '0;
    repeat (3) @(negedge clk);
    #1;
    // R1 reset state
    check("R1 bus idle", bus_vld, 1'b0);
    check("R1 wr_rdy", wr_rdy, 1'b1);
    check("R1 stall_cnt", stall_cnt, 16'd0);
    check("R1 prot_map", prot_map, 8'h0E);
    @(negedge clk); rst_n = 1'b1;
    repeat (3) @(negedge clk);

    for (int i = 0; i < NV; i++)
      run_pair(VEC[i].wa, VEC[i].ra, VEC[i].wt, VEC[i].rt, VEC[i].ord,
               $sformatf("R%0d row %0d", VEC[i].req, i));

    // R9 lone read, data passthrough and bus back-pressure
    @(negedge clk);
    rd_vld = 1'b1; rd_addr = 16'h2222; rd_tag = 4'd3; bus_rdata = 16'h5A5A; bus_rdy = 1'b0;
    #1;
    check("R9 read on bus, not ready", {bus_vld, bus_we, rd_rdy}, 3'b100);
    @(negedge clk); bus_rdy = 1'b1; #1;
    check("R9 read completes", {bus_vld, rd_rdy}, 2'b11);
    check("R9 read data", rd_rdata, 16'h5A5A);
    check("R9 read address", bus_addr, 16'h2222);
    @(negedge clk); rd_vld = 1'b0;

    // R6 and R7: write held while the bus is busy, second write refused
    wr_vld = 1'b1; wr_addr = 16'h4010; wr_data = 16'h1234; wr_tag = 4'd4;
    @(negedge clk);
    wr_vld = 1'b0; bus_rdy = 1'b0;
    #1;
    check("R6 wr_rdy low while buffered", wr_rdy, 1'b0);
    begin
      logic [15:0] base;
      base = stall_cnt;
      wr_vld = 1'b1; wr_addr = 16'h0888; wr_data = 16'hBEEF; wr_tag = 4'd6;
      rd_vld = 1'b1; rd_addr = 16'h8000; rd_tag = 4'd5;
      for (int k = 0; k < 3; k++) begin
        #1;
        check("R6 write held on bus", {bus_vld, bus_we, rd_rdy}, 3'b110);
        check("R6 held address", bus_addr, 16'h4010);
        check("R6 held data", bus_wdata, 16'h1234);
        @(negedge clk);
      end
      wr_vld = 1'b0; bus_rdy = 1'b1;
      #1;
      check("R3 write completes first", {bus_we, rd_rdy}, 2'b10);
      @(negedge clk); #1;
      check("R3 read follows", {bus_vld, bus_we, rd_rdy}, 3'b101);
      check("R7 stall count under back-pressure", stall_cnt - base, 16'd4);
      @(negedge clk); rd_vld = 1'b0; #1;
      check("R6 refused write not buffered", bus_vld, 1'b0);
    end

    // R8 map rewrite changes the decision for the same pair
    @(negedge clk); cfg_we = 1'b1; cfg_data = 8'h00;
    @(negedge clk); cfg_we = 1'b0; #1;
    check("R8 map cleared", prot_map, 8'h00);
    run_pair(16'h2004, 16'h8020, 4'd1, 4'd2, 1'b0, "R8 region 1 unprotected");
    run_pair(16'h3000, 16'h3000, 4'd2, 4'd3, 1'b1, "R4 same address, empty map");
    @(negedge clk); cfg_we = 1'b1; cfg_data = 8'h10;
    @(negedge clk); cfg_we = 1'b0; #1;
    check("R8 map region 4", prot_map, 8'h10);
    run_pair(16'h8000, 16'h0004, 4'd5, 4'd6, 1'b1, "R8 region 4 protected");

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule